// File: doc/BRIEF.md
# Gated Multiplexed Clock Fanout

This block fans one selected source clock out to six output pairs. A select line picks either the fast system clock or a slower scan/test clock. Every pair can be stopped and restarted without producing a shortened high pulse. It is meant for a clock tree that has to distribute a test clock through the same branches as the system clock, and that has to shut individual branches down cleanly.

All enables are active low. A shared enable gates all six pairs and a per-pair enable gates each pair on its own. Both are captured on the falling edge of whichever clock is currently selected. Each pair is gated by its captured value, which is the AND of the two enables. The captured value changes only while the clock is low, so a pair always starts or stops at a clock-low boundary. A stopped pair rests with its true line LOW and its complement line HIGH. An asynchronous active-low reset forces every capture flop to the stopped state, because those flops otherwise come up in an unknown state. Tie the select input LOW when the test clock is not used. There are no data streams, so every pin is a plain control or clock pin.

Top module: `clk_fanout_gate`

## Requirements
- R1: With `src_sel` = 0, every running pair follows `sys_clk`. With `src_sel` = 1, every running pair follows `tst_clk`.
- R2: Pair i runs only when both `com_en_n` = 0 and `out_en_n[i]` = 0 were sampled at the latest falling edge of the selected clock. Any other combination stops pair i, independently of the other pairs.
- R3: When `com_en_n` = 1 is sampled at a falling edge, all six pairs stop from that same edge.
- R4: During each high phase of the selected clock, a pair's state reflects the enables sampled at the falling edge just before it. A change of enable therefore takes effect exactly one falling edge later.
- R5: Edges of the clock that is not selected never sample the enables.
- R6: Every high pulse on `ck_p` lasts the full high phase of the selected clock, and all `ck_p` lines are LOW whenever the selected clock is LOW.
- R7: A stopped pair holds `ck_p[i]` = 0 and `ck_n[i]` = 1, and `ck_n` is always the complement of `ck_p`.
- R8: While `rst_n` = 0, all capture flops are held in the stopped state at once, so every pair is parked. This happens without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | High-speed system clock source |
| tst_clk | input | 1 | Slower scan/test clock source |
| src_sel | input | 1 | 0 selects sys_clk, 1 selects tst_clk |
| rst_n | input | 1 | Asynchronous active-low reset of the capture flops to stopped |
| com_en_n | input | 1 | Shared active-low enable for all pairs |
| out_en_n | input | 6 | Per-pair active-low enables |
| ck_p | output | 6 | True gated clock per pair |
| ck_n | output | 6 | Complement gated clock per pair |

## Verification
Random enable words are applied to both clock sources, with the select input switching only while both clocks are low. A bench model of the capture flops predicts every high phase, which separates one-edge-late capture from immediate or two-edge-late capture. It also catches the per-pair enable being ignored or cross-wired. A directed step with the test clock selected changes the enables just before an unselected system-clock falling edge, which shows whether the wrong clock samples them. Measured pulse widths on each true output, compared with the selected clock's high phase, expose runt pulses and routing of the wrong source. A reset applied mid-run shows that the outputs park asynchronously.

// File: rtl/clk_fanout_pkg.sv
`timescale 1ns/1ps
package clk_fanout_pkg;
  localparam int unsigned FANOUT_DEFAULT = 6;
  typedef enum logic {SRC_SYSTEM = 1'b0, SRC_TEST = 1'b1} src_e;
endpackage

// File: rtl/clk_src_sel.sv
`timescale 1ns/1ps
module clk_src_sel
  import clk_fanout_pkg::*;
(
  input  logic sys_clk,
  input  logic tst_clk,
  input  logic src_sel,
  output logic clk_o
);
  src_e src;
  assign src   = src_e'(src_sel);
  assign clk_o = (src == SRC_TEST) ? tst_clk : sys_clk;
endmodule

// File: rtl/en_capture.sv
`timescale 1ns/1ps
module en_capture #(
  parameter int unsigned N_OUT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             com_en_n,
  input  logic [N_OUT-1:0] ind_en_n,
  output logic [N_OUT-1:0] run
);
  // Combined enable captured on the falling edge, so it is stable
  // across the entire following high phase.
  for (genvar i = 0; i < N_OUT; i++) begin : g_flop
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) run[i] <= 1'b0;
      else        run[i] <= ~com_en_n & ~ind_en_n[i];
    end
  end
endmodule

// File: rtl/gate_pair.sv
`timescale 1ns/1ps
module gate_pair (
  input  logic clk,
  input  logic run,
  output logic pos,
  output logic neg
);
  logic gated;
  assign gated = clk & run;
  assign pos   = gated;
  assign neg   = ~gated;
endmodule

// File: rtl/clk_fanout_gate.sv
`timescale 1ns/1ps
module clk_fanout_gate
  import clk_fanout_pkg::*;
#(
  parameter int unsigned N_OUT = FANOUT_DEFAULT
) (
  input  logic             sys_clk,
  input  logic             tst_clk,
  input  logic             src_sel,
  input  logic             rst_n,
  input  logic             com_en_n,
  input  logic [N_OUT-1:0] out_en_n,
  output logic [N_OUT-1:0] ck_p,
  output logic [N_OUT-1:0] ck_n
);
  logic             src_clk;
  logic [N_OUT-1:0] run;

  clk_src_sel u_sel (
    .sys_clk (sys_clk),
    .tst_clk (tst_clk),
    .src_sel (src_sel),
    .clk_o   (src_clk)
  );

  en_capture #(.N_OUT(N_OUT)) u_cap (
    .clk      (src_clk),
    .rst_n    (rst_n),
    .com_en_n (com_en_n),
    .ind_en_n (out_en_n),
    .run      (run)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_pair
    gate_pair u_gp (
      .clk (src_clk),
      .run (run[i]),
      .pos (ck_p[i]),
      .neg (ck_n[i])
    );
  end
endmodule

// File: rtl/clk_fanout_gate_chk.sv
`timescale 1ns/1ps
module clk_fanout_gate_chk #(
  parameter int unsigned N_OUT = 6
) (
  input logic             sys_clk,
  input logic             tst_clk,
  input logic             src_sel,
  input logic             rst_n,
  input logic             com_en_n,
  input logic [N_OUT-1:0] out_en_n,
  input logic [N_OUT-1:0] ck_p,
  input logic [N_OUT-1:0] ck_n
);
  logic ck;
  logic armed;
  assign ck = src_sel ? tst_clk : sys_clk;

  always_ff @(negedge ck or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R4: high phase before a falling edge reflects enables of the previous falling edge
  for (genvar g = 0; g < N_OUT; g++) begin : g_follow
    a_r4_follow: assert property (@(negedge ck) disable iff (!rst_n || !armed)
      ck_p[g] == $past(!com_en_n && !out_en_n[g]));
  end

  // R3: shared disable stops every pair in the next high phase
  a_r3_common_stop: assert property (@(negedge ck) disable iff (!rst_n)
    com_en_n |=> (ck_p == '0));

  // R6: no output is high while the selected clock is low
  a_r6_low_quiet: assert property (@(posedge ck) disable iff (!rst_n)
    ck_p == '0);

  // R8: with reset held, the high phase produces no pulses
  a_r8_reset_park: assert property (@(negedge ck) disable iff (rst_n)
    $past(!rst_n) |-> (ck_p == '0 && ck_n == '1));
endmodule

bind clk_fanout_gate clk_fanout_gate_chk #(.N_OUT(N_OUT)) u_chk (
  .sys_clk  (sys_clk),
  .tst_clk  (tst_clk),
  .src_sel  (src_sel),
  .rst_n    (rst_n),
  .com_en_n (com_en_n),
  .out_en_n (out_en_n),
  .ck_p     (ck_p),
  .ck_n     (ck_n)
);

// File: tb/sim_clk_fanout_gate.sv
`timescale 1ns/1ps
module sim_clk_fanout_gate;
  localparam int N = 6;

  logic         sys_clk = 1'b0;
  logic         tst_clk = 1'b0;
  logic         src_sel = 1'b0;
  logic         rst_n   = 1'b0;
  logic         com_en_n = 1'b1;
  logic [N-1:0] out_en_n = '1;
  logic [N-1:0] ck_p, ck_n;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  string cur_tag = "R8";
  logic [N-1:0] exp_run = '0;

  clk_fanout_gate #(.N_OUT(N)) u0 (
    .sys_clk(sys_clk), .tst_clk(tst_clk), .src_sel(src_sel), .rst_n(rst_n),
    .com_en_n(com_en_n), .out_en_n(out_en_n), .ck_p(ck_p), .ck_n(ck_n)
  );

  // 200 MHz system clock; test clock at one quarter of that.
  always #2.5 sys_clk = ~sys_clk;
  always #10  tst_clk = ~tst_clk;

  logic ck_exp;
  assign ck_exp = src_sel ? tst_clk : sys_clk;

  function automatic logic [N-1:0] run_of(input logic c, input logic [N-1:0] e);
    return c ? '0 : ~e;
  endfunction

  // Bench model of the capture point: falling edge of the selected clock.
  always @(negedge ck_exp or negedge rst_n) begin
    if (!rst_n) exp_run = '0;
    else        exp_run = run_of(com_en_n, out_en_n);
  end

  task automatic chk(input bit ok, input string tag, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: %s", tag, $time, detail);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // High-phase and low-phase observation, 1 ns after each selected edge.
  always @(posedge ck_exp) begin
    #1;
    if (!done) begin
      chk(ck_p == exp_run, cur_tag,
          $sformatf("ck_p actual %b expected %b", ck_p, exp_run));
      chk(ck_n == ~ck_p, "R7",
          $sformatf("ck_n actual %b expected %b", ck_n, ~ck_p));
    end
  end

  always @(negedge ck_exp) begin
    #1;
    if (!done) begin
      chk(ck_p == '0, "R6", $sformatf("low phase ck_p actual %b expected 000000", ck_p));
      chk(ck_n == '1, "R7", $sformatf("low phase ck_n actual %b expected 111111", ck_n));
    end
  end

  // Pulse width on every true output must equal the selected high phase.
  for (genvar g = 0; g < N; g++) begin : g_width
    realtime t_rise;
    bit      seen = 1'b0;
    always @(posedge ck_p[g]) begin
      t_rise = $realtime;
      seen   = 1'b1;
    end
    always @(negedge ck_p[g]) begin
      if (seen && !done) begin
        realtime w, we;
        w  = $realtime - t_rise;
        we = src_sel ? 10.0 : 2.5;
        chk((w > we - 0.01) && (w < we + 0.01), "R6",
            $sformatf("pulse on ck_p[%0d] width %0t expected %0t", g, w, we));
      end
    end
  end

  // Inputs change 2 ns after a system-clock falling edge.
  task automatic step(input int n);
    repeat (n) @(negedge sys_clk);
    #2;
  endtask

  task automatic align20();
    step(1);
    while (($rtoi($realtime) % 20) != 2) step(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // R8: reset state with enables asserted but reset held
    com_en_n = 1'b0;
    out_en_n = '0;
    step(2);
    #1;
    chk(ck_p == '0 && ck_n == '1, "R8",
        $sformatf("in reset ck_p %b ck_n %b expected 000000/111111", ck_p, ck_n));
    step(1);
    rst_n = 1'b1;

    // R1: system clock routed
    cur_tag = "R1";
    step(8);
    // R2: individual patterns
    cur_tag = "R2";
    out_en_n = 6'b101010; step(3);
    out_en_n = 6'b010101; step(3);
    out_en_n = 6'b111110; step(3);
    out_en_n = 6'b000000; step(3);

    // R3: shared disable stops all pairs on the same edge
    cur_tag = "R3";
    com_en_n = 1'b1;
    #1;
    chk(ck_p == '1, "R3", $sformatf("before capture ck_p %b expected 111111", ck_p));
    #5;
    chk(ck_p == '0, "R3", $sformatf("after capture ck_p %b expected 000000", ck_p));
    step(1);
    com_en_n = 1'b0;
    step(3);

    // R1: test clock routed; R5: unselected edges do not sample
    align20();
    src_sel = 1'b1;
    cur_tag = "R1";
    step(1);
    com_en_n = 1'b1;
    #8;
    chk(ck_p == '1, "R5", $sformatf("system edge sampled: ck_p %b expected 111111", ck_p));
    #20;
    chk(ck_p == '0, "R5", $sformatf("test edge capture: ck_p %b expected 000000", ck_p));
    step(1);
    com_en_n = 1'b0;
    out_en_n = 6'b110011;
    step(12);
    align20();
    src_sel = 1'b0;
    out_en_n = '0;
    step(4);

    // R4: random enables with occasional source switching
    cur_tag = "R4";
    for (int k = 0; k < 700; k++) begin
      if ((($rtoi($realtime) % 20) == 2) && ($urandom % 6 == 0)) src_sel = ~src_sel;
      com_en_n = ($urandom % 7 == 0);
      for (int b = 0; b < N; b++) out_en_n[b] = ($urandom % 4 == 0);
      step(1 + ($urandom % 3));
    end

    // R8: asynchronous reset mid-run, applied in a system-clock low phase
    align20();
    src_sel = 1'b0;
    com_en_n = 1'b0;
    out_en_n = '0;
    step(3);
    rst_n = 1'b0;
    #0.2;
    chk(ck_p == '0 && ck_n == '1, "R8",
        $sformatf("async reset ck_p %b ck_n %b expected 000000/111111", ck_p, ck_n));
    #1.5;
    chk(ck_p == '0, "R8", $sformatf("reset high phase ck_p %b expected 000000", ck_p));
    step(2);
    rst_n = 1'b1;
    cur_tag = "R4";
    step(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule